// File: doc/BRIEF.md
# Per-Instruction Prefetcher Routing Table

This block stands in front of a group of hardware prefetchers and decides, for every demand access, which of them get to see it. It keeps a small direct-mapped table keyed by the load's instruction address. Every table row holds one three-way suitability state for each prefetcher. A lookup turns those states into a routing mask (one bit per prefetcher) and a prefetch degree per prefetcher. A prefetcher that has not yet been judged trains at a modest degree. A prefetcher judged effective for that instruction trains at a raised degree. A prefetcher judged harmful for it is cut off.

A second port brings usefulness verdicts from an external measurement unit, one instruction address and one prefetcher at a time. Verdicts move the per-prefetcher state machines. An opposite verdict always sends a settled state back to the undecided state, so the choice can be learned again when program behaviour shifts. With the default parameters (64 rows, 3 prefetchers, 32-bit addresses) the whole table is 64 x (1 valid + 24 tag + 6 state) = 1984 bits, which stays well under one kilobyte.

Top module: `pf_route_table`

## Requirements
- R1: After reset, outValid is 0, outMask and outDegree are 0, and no table row is valid, so the first lookup of any address is a miss.
- R2: outValid is 1 in exactly the cycle after a cycle with reqValid 1, and the mask and degrees in that cycle belong to that request.
- R3: The row index is reqPc[7:2] and the tag is reqPc[31:8]. A lookup whose row is invalid or holds another tag replaces the row with the new tag and every prefetcher undecided, which discards the old address's states.
- R4: An undecided prefetcher (state 0) has its mask bit set and degree 1. Prefetcher p's degree occupies outDegree[3p+2:3p].
- R5: The verdict useful (fbVerdict 2'b01) moves an undecided prefetcher to aggressive (state 1). An aggressive prefetcher has its mask bit set and degree 4.
- R6: The verdict useless (2'b10) moves an undecided prefetcher to blocked (state 2). A blocked prefetcher has its mask bit clear and degree 0.
- R7: Useless on an aggressive prefetcher, or useful on a blocked one, returns it to undecided. Useful on aggressive and useless on blocked leave the state unchanged.
- R8: A verdict of 2'b00 or 2'b11, a prefetcher index of 3 or more, or fbValid 0 changes no state.
- R9: Feedback for an address whose row is invalid or holds another tag changes no state and allocates no row.
- R10: When a lookup and a feedback update hit the same row in one cycle, the lookup's outputs already reflect the update.
- R11: Feedback changes only the addressed prefetcher's state in the addressed row. States of other prefetchers and other rows are kept.
- R12: In any cycle with outValid 0, outMask and outDegree are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Demand access present |
| reqPc | input | 32 | Instruction address of the demand access |
| fbValid | input | 1 | Feedback verdict present |
| fbPc | input | 32 | Instruction address the verdict concerns |
| fbPf | input | 2 | Prefetcher the verdict concerns |
| fbVerdict | input | 2 | 01 useful, 10 useless, 00 and 11 no verdict |
| outValid | output | 1 | Routing decision present |
| outMask | output | 3 | Bit p set: prefetcher p receives the access |
| outDegree | output | 9 | 3-bit prefetch degree per prefetcher, prefetcher 0 lowest |

## Verification
The hardest case to reach from the ports is the cycle where a lookup and a verdict meet in one row. A lookup with a different tag at the same index must also win over a verdict aimed at the row's old owner. The stimulus first places an address in each of the three states. It then issues the lookup and the verdict on the same clock, for both a matching tag and an aliasing tag. A reference model in the bench applies the verdict before the lookup. Every one of the 48 combinations of start state, prefetcher index and verdict code is also reached. Each uses a fresh address, so every transition, including the ignored ones, is seen at the outputs.

// File: rtl/pf_route_pkg.sv
package pf_route_pkg;

  // Suitability state codes (per instruction, per prefetcher)
  localparam logic [1:0] SUIT_UNKNOWN = 2'd0;
  localparam logic [1:0] SUIT_AGGR    = 2'd1;
  localparam logic [1:0] SUIT_BLOCK   = 2'd2;

  // Feedback verdict codes
  localparam logic [1:0] VERD_GOOD = 2'b01;
  localparam logic [1:0] VERD_BAD  = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic lkFire;   // a lookup is processed this cycle
    logic lkAlloc;  // the lookup misses and replaces its row
    logic fbApply;  // a usable verdict hits a resident row
    logic fbMerge;  // that verdict targets the lookup's row
  } tblCtl_t;

  function automatic logic [1:0] nextSuit(input logic [1:0] cur, input logic [1:0] verd);
    logic [1:0] nxt;
    nxt = cur;
    unique case (cur)
      SUIT_UNKNOWN: begin
        if (verd == VERD_GOOD) nxt = SUIT_AGGR;
        else if (verd == VERD_BAD) nxt = SUIT_BLOCK;
      end
      SUIT_AGGR:  if (verd == VERD_BAD)  nxt = SUIT_UNKNOWN;
      SUIT_BLOCK: if (verd == VERD_GOOD) nxt = SUIT_UNKNOWN;
      default:    nxt = SUIT_UNKNOWN;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pf_route_ctrl.sv
module pf_route_ctrl
  import pf_route_pkg::*;
#(
  parameter int NUM_PF   = 3,
  parameter int PF_SEL_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                fbValid,
  input  logic [PF_SEL_W-1:0] fbPf,
  input  logic [1:0]          fbVerdict,
  input  logic                lkTagHit,
  input  logic                fbTagHit,
  input  logic                sameRow,
  output tblCtl_t             ctl
);

  logic fbUsable;

  always_comb begin
    fbUsable = fbValid
             && (fbPf < PF_SEL_W'(NUM_PF))
             && ((fbVerdict == VERD_GOOD) || (fbVerdict == VERD_BAD));
    ctl.lkFire  = reqValid;
    ctl.lkAlloc = reqValid && !lkTagHit;
    ctl.fbApply = fbUsable && fbTagHit;
    ctl.fbMerge = fbUsable && fbTagHit && reqValid && sameRow;
  end

  // R10: a merged update implies the lookup row is resident, never a fresh allocation
  a_r10_merge_not_alloc: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fbMerge |-> !ctl.lkAlloc);

  // R8: no verdict moves state unless a verdict was presented
  a_r8_apply_needs_fb: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fbApply |-> fbValid);

endmodule

// File: rtl/pf_route_dp.sv
module pf_route_dp
  import pf_route_pkg::*;
#(
  parameter int NUM_PF   = 3,
  parameter int ENTRIES  = 64,
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int DEG_W    = 3,
  parameter int DEF_DEG  = 1,
  parameter int AGG_DEG  = 4,
  parameter int PF_SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PC_W-1:0]         reqPc,
  input  logic [PC_W-1:0]         fbPc,
  input  logic [PF_SEL_W-1:0]     fbPf,
  input  logic [1:0]              fbVerdict,
  input  tblCtl_t                 ctl,
  output logic                    lkTagHit,
  output logic                    fbTagHit,
  output logic                    sameRow,
  output logic                    outValid,
  output logic [NUM_PF-1:0]       outMask,
  output logic [NUM_PF*DEG_W-1:0] outDegree
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - PC_SHIFT - IDX_W;
  localparam int ROW_W = 2 * NUM_PF;

  logic [ENTRIES-1:0] rowValid;
  logic [TAG_W-1:0]   rowTag [ENTRIES];
  logic [ROW_W-1:0]   rowSt  [ENTRIES];

  logic [IDX_W-1:0] lkIdx, fbIdx;
  logic [TAG_W-1:0] lkTag, fbTag;
  logic [ROW_W-1:0] fbRow, lkRow;
  logic [NUM_PF-1:0]       maskNext;
  logic [NUM_PF*DEG_W-1:0] degNext;

  generate
    if (PC_SHIFT > 0) begin : g_low
      logic unusedLowBits;
      assign unusedLowBits = ^{reqPc[PC_SHIFT-1:0], fbPc[PC_SHIFT-1:0]};
    end
  endgenerate

  assign lkIdx = reqPc[PC_SHIFT +: IDX_W];
  assign fbIdx = fbPc[PC_SHIFT +: IDX_W];
  assign lkTag = reqPc[PC_W-1 -: TAG_W];
  assign fbTag = fbPc[PC_W-1 -: TAG_W];

  assign lkTagHit = rowValid[lkIdx] && (rowTag[lkIdx] == lkTag);
  assign fbTagHit = rowValid[fbIdx] && (rowTag[fbIdx] == fbTag);
  assign sameRow  = (lkIdx == fbIdx) && (lkTag == fbTag);

  // Feedback row after applying the verdict to the selected prefetcher
  always_comb begin
    fbRow = rowSt[fbIdx];
    for (int p = 0; p < NUM_PF; p++) begin
      if (fbPf == PF_SEL_W'(p))
        fbRow[2*p +: 2] = nextSuit(rowSt[fbIdx][2*p +: 2], fbVerdict);
    end
  end

  // Lookup row: fresh on allocation, bypassed update on merge
  always_comb begin
    if (ctl.lkAlloc)      lkRow = '0;
    else if (ctl.fbMerge) lkRow = fbRow;
    else                  lkRow = rowSt[lkIdx];
  end

  // Per-prefetcher decode of state into routing bit and degree
  generate
    for (genvar p = 0; p < NUM_PF; p++) begin : g_dec
      logic [1:0] st;
      assign st = lkRow[2*p +: 2];
      always_comb begin
        maskNext[p] = (st != SUIT_BLOCK);
        unique case (st)
          SUIT_AGGR:  degNext[p*DEG_W +: DEG_W] = DEG_W'(AGG_DEG);
          SUIT_BLOCK: degNext[p*DEG_W +: DEG_W] = '0;
          default:    degNext[p*DEG_W +: DEG_W] = DEG_W'(DEF_DEG);
        endcase
      end

      // R6: a prefetcher left out of the mask is never given a degree
      a_r6_blocked_no_degree: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && !outMask[p]) |-> (outDegree[p*DEG_W +: DEG_W] == '0));

      // R4/R5: any routed prefetcher runs at one of the two legal degrees
      a_r5_routed_degree: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outMask[p]) |->
          ((outDegree[p*DEG_W +: DEG_W] == DEG_W'(DEF_DEG)) ||
           (outDegree[p*DEG_W +: DEG_W] == DEG_W'(AGG_DEG))));
    end
  endgenerate

  // Row valid bits
  always_ff @(posedge clk) begin
    if (!rstN) rowValid <= '0;
    else if (ctl.lkAlloc) rowValid[lkIdx] <= 1'b1;
  end

  // Row payload; an allocation overrides a verdict to the same row
  always_ff @(posedge clk) begin
    if (ctl.fbApply) rowSt[fbIdx] <= fbRow;
    if (ctl.lkAlloc) begin
      rowTag[lkIdx] <= lkTag;
      rowSt[lkIdx]  <= '0;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outMask   <= '0;
      outDegree <= '0;
    end else begin
      outValid  <= ctl.lkFire;
      outMask   <= ctl.lkFire ? maskNext : '0;
      outDegree <= ctl.lkFire ? degNext  : '0;
    end
  end

  // R12: idle outputs stay quiet
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ((outMask == '0) && (outDegree == '0)));

  // R3: a fresh allocation routes to every prefetcher
  a_r3_alloc_all_routed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lkAlloc |=> (&outMask));

  // R9: rows become valid only through a lookup miss
  a_r9_valid_only_on_alloc: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lkAlloc |=> $stable(rowValid));

endmodule

// File: rtl/pf_route_table.sv
module pf_route_table
  import pf_route_pkg::*;
#(
  parameter int NUM_PF   = 3,
  parameter int ENTRIES  = 64,
  parameter int PC_W     = 32,
  parameter int PC_SHIFT = 2,
  parameter int DEG_W    = 3,
  parameter int DEF_DEG  = 1,
  parameter int AGG_DEG  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [PC_W-1:0]               reqPc,
  input  logic                          fbValid,
  input  logic [PC_W-1:0]               fbPc,
  input  logic [$clog2(NUM_PF+1)-1:0]   fbPf,
  input  logic [1:0]                    fbVerdict,
  output logic                          outValid,
  output logic [NUM_PF-1:0]             outMask,
  output logic [NUM_PF*DEG_W-1:0]       outDegree
);

  localparam int PF_SEL_W = $clog2(NUM_PF + 1);

  tblCtl_t ctl;
  logic    lkTagHit, fbTagHit, sameRow;

  pf_route_ctrl #(
    .NUM_PF(NUM_PF), .PF_SEL_W(PF_SEL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .fbValid(fbValid), .fbPf(fbPf), .fbVerdict(fbVerdict),
    .lkTagHit(lkTagHit), .fbTagHit(fbTagHit), .sameRow(sameRow),
    .ctl(ctl)
  );

  pf_route_dp #(
    .NUM_PF(NUM_PF), .ENTRIES(ENTRIES), .PC_W(PC_W), .PC_SHIFT(PC_SHIFT),
    .DEG_W(DEG_W), .DEF_DEG(DEF_DEG), .AGG_DEG(AGG_DEG), .PF_SEL_W(PF_SEL_W)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .reqPc(reqPc), .fbPc(fbPc), .fbPf(fbPf), .fbVerdict(fbVerdict),
    .ctl(ctl),
    .lkTagHit(lkTagHit), .fbTagHit(fbTagHit), .sameRow(sameRow),
    .outValid(outValid), .outMask(outMask), .outDegree(outDegree)
  );

  // R2: one-cycle decision latency, in both directions
  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  a_r2_idle_follows_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

endmodule

// File: tb/test_pf_route_table.sv
module test_pf_route_table;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqPc = '0;
  logic        fbValid = 1'b0;
  logic [31:0] fbPc = '0;
  logic [1:0]  fbPf = '0;
  logic [1:0]  fbVerdict = '0;
  logic        outValid;
  logic [2:0]  outMask;
  logic [8:0]  outDegree;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // Reference model of the table
  bit          mValid [64];
  logic [23:0] mTag   [64];
  int          mSt    [64][3];

  always #4 clk = ~clk;  // 125 MHz

  pf_route_table i_pf_route_table (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPc(reqPc),
    .fbValid(fbValid), .fbPc(fbPc), .fbPf(fbPf), .fbVerdict(fbVerdict),
    .outValid(outValid), .outMask(outMask), .outDegree(outDegree)
  );

  function automatic logic [31:0] mkPc(input int idx, input int tag);
    return {tag[23:0], idx[5:0], 2'b00};
  endfunction

  function automatic int trans(input int s, input int v);
    if (v == 1) return (s == 0) ? 1 : (s == 2) ? 0 : s;
    if (v == 2) return (s == 0) ? 2 : (s == 1) ? 0 : s;
    return s;
  endfunction

  task automatic check(input string req, input bit ev, input logic [2:0] em, input logic [8:0] ed);
    nTests++;
    if (outValid !== ev || outMask !== em || outDegree !== ed) begin
      nFail++;
      $display("FAIL %s: valid/mask/degree got %0b/%03b/%03h expected %0b/%03b/%03h",
               req, outValid, outMask, outDegree, ev, em, ed);
    end
  endtask

  // One clock: drive both ports, update the model (verdict first), check outputs.
  task automatic step(input bit rv, input logic [31:0] rpc, input bit fv,
                      input logic [31:0] fpc, input int fpf, input int fverd,
                      input string req);
    int fi, li;
    bit ev;
    logic [2:0] em;
    logic [8:0] ed;
    fi = int'(fpc[7:2]);
    li = int'(rpc[7:2]);
    if (fv && fpf < 3 && (fverd == 1 || fverd == 2) && mValid[fi] && mTag[fi] == fpc[31:8])
      mSt[fi][fpf] = trans(mSt[fi][fpf], fverd);
    ev = rv; em = '0; ed = '0;
    if (rv) begin
      if (!(mValid[li] && mTag[li] == rpc[31:8])) begin
        mValid[li] = 1'b1;
        mTag[li] = rpc[31:8];
        for (int p = 0; p < 3; p++) mSt[li][p] = 0;
      end
      for (int p = 0; p < 3; p++) begin
        em[p] = (mSt[li][p] != 2);
        ed[p*3 +: 3] = (mSt[li][p] == 0) ? 3'd1 : (mSt[li][p] == 1) ? 3'd4 : 3'd0;
      end
    end
    reqValid = rv; reqPc = rpc;
    fbValid = fv; fbPc = fpc; fbPf = fpf[1:0]; fbVerdict = fverd[1:0];
    @(posedge clk);
    #2;
    reqValid = 1'b0; fbValid = 1'b0;
    check(req, ev, em, ed);
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(1'b1, pc, 1'b0, '0, 0, 0, req);
  endtask

  task automatic fb(input logic [31:0] pc, input int pf, input int v, input string req);
    step(1'b0, '0, 1'b1, pc, pf, v, req);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finishRun();
  end

  initial begin
    int cnt;
    for (int i = 0; i < 64; i++) mValid[i] = 1'b0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset", 1'b0, 3'b000, 9'h000);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 after reset", 1'b0, 3'b000, 9'h000);
    look(mkPc(0, 24'h000000), "R1 first lookup misses");
    look(mkPc(0, 24'h000000), "R4 hit on undecided row");

    // R2: back-to-back lookups and idle gaps
    look(mkPc(1, 5), "R2 back to back a");
    look(mkPc(2, 5), "R2 back to back b");
    step(1'b0, '0, 1'b0, '0, 0, 0, "R2 idle after request");

    // R5 R6 R7 R8 R11: exhaustive start state x prefetcher index x verdict
    cnt = 0;
    for (int s = 0; s < 3; s++) begin
      for (int pf = 0; pf < 4; pf++) begin
        for (int v = 0; v < 4; v++) begin
          logic [31:0] pc;
          pc = mkPc(cnt % 64, 24'h100 + cnt);
          cnt++;
          look(pc, "R3 fresh row");
          if (s != 0)
            for (int p = 0; p < 3; p++) fb(pc, p, s, "R12 idle during feedback");
          look(pc, s == 1 ? "R5 start aggressive" : s == 2 ? "R6 start blocked" : "R4 start undecided");
          fb(pc, pf, v, "R12 idle during feedback");
          look(pc, (pf > 2 || v == 0 || v == 3) ? "R8 ignored verdict" : "R7 transition");
        end
      end
    end

    // R11: distinct states in every row, then read them all back
    for (int i = 0; i < 64; i++) begin
      logic [31:0] pc;
      pc = mkPc(i, 24'h5A0 + i);
      look(pc, "R3 fill row");
      for (int p = 0; p < 3; p++)
        if ((i + p) % 3 != 0) fb(pc, p, (i + p) % 3, "R12 idle during feedback");
    end
    for (int i = 0; i < 64; i++) look(mkPc(i, 24'h5A0 + i), "R11 rows independent");

    // R9: feedback to a non-resident address
    look(mkPc(5, 24'hABC), "R3 resident A");
    fb(mkPc(5, 24'hABD), 0, 1, "R9 alias feedback");
    fb(mkPc(5, 24'hABD), 1, 2, "R9 alias feedback");
    look(mkPc(5, 24'hABC), "R9 alias feedback ignored");
    fb(mkPc(9, 24'hDDD), 2, 2, "R9 absent feedback");
    look(mkPc(9, 24'hDDD), "R9 absent feedback allocates nothing");

    // R3: aliasing lookup evicts the old owner
    look(mkPc(7, 24'h111), "R3 owner");
    fb(mkPc(7, 24'h111), 0, 1, "R12 idle during feedback");
    fb(mkPc(7, 24'h111), 2, 2, "R12 idle during feedback");
    look(mkPc(7, 24'h111), "R5 owner trained");
    look(mkPc(7, 24'h222), "R3 alias replaces row");
    look(mkPc(7, 24'h111), "R3 old owner lost");

    // R10: lookup and verdict in the same cycle
    look(mkPc(12, 24'h333), "R3 merge row");
    step(1'b1, mkPc(12, 24'h333), 1'b1, mkPc(12, 24'h333), 1, 1, "R10 same row update first");
    step(1'b1, mkPc(12, 24'h333), 1'b1, mkPc(12, 24'h333), 1, 2, "R10 same row return");
    step(1'b1, mkPc(12, 24'h333), 1'b1, mkPc(12, 24'h333), 0, 2, "R10 same row block");
    look(mkPc(12, 24'h333), "R10 merged state kept");
    fb(mkPc(12, 24'h333), 2, 1, "R12 idle during feedback");
    step(1'b1, mkPc(12, 24'h444), 1'b1, mkPc(12, 24'h333), 1, 1, "R10 alias lookup beats verdict");
    look(mkPc(12, 24'h333), "R10 evicted owner fresh");
    look(mkPc(20, 24'h555), "R3 side row");
    step(1'b1, mkPc(21, 24'h666), 1'b1, mkPc(20, 24'h555), 2, 1, "R10 miss and verdict apart");
    look(mkPc(20, 24'h555), "R11 side verdict applied");

    finishRun();
  end

endmodule